// File: doc/BRIEF.md
# Touch-panel ADC scan sequencer

This block runs a complete measurement pass over an eight-input resistive-touch converter that hangs off a mode-0 serial bus. A single start pulse makes it visit every channel whose enable bit is set, from the lowest address to the highest. For each visited channel it sends a burst of conversion frames. The first part of the burst only lets the panel plates settle, and those replies are thrown away. The rest of the burst is summed and divided, rounding up, to give one 12-bit value per channel.

The settling count, the oversampling count, the enable mask and the reference choice are sampled once, when the start pulse is accepted. Results are stored densely: slot 0 holds the lowest enabled channel, slot 1 the next one, and so on. A one-cycle done pulse marks the end of the pass.

The state machine has six states:

- ST_IDLE: waiting for start.
- ST_SEEK: testing the enable bit of the current address.
- ST_ISSUE: launching one frame.
- ST_WAIT: waiting for that frame to end.
- ST_STORE: writing the averaged result.
- ST_FIN: pulsing done.

Its transitions are:

- IDLE to SEEK on start.
- SEEK to ISSUE when the address is enabled.
- SEEK to SEEK when the address is disabled and is not the last one.
- SEEK to FIN when the last address is disabled.
- ISSUE to WAIT.
- WAIT to ISSUE when a frame ends that is not the last of its group.
- WAIT to STORE when the last frame of the group ends.
- STORE to SEEK when more addresses remain.
- STORE to FIN after the last address.
- FIN to IDLE.

Top module: `touch_scan_seq`

## Requirements
- R1: Each frame is 24 SCLK periods. SCLK idles low. MOSI changes only while SCLK is low, MSB first, and MISO is sampled on the rising edge. cs_n is low for the whole pass and high when idle, and SCLK stays low while cs_n is high.
- R2: In every command byte, bit 7 is 1, bits 6:4 carry the channel address, and bit 3 (the 8-bit mode select) is 0.
- R3: Bit 2 (single-ended) is 1 exactly for addresses 0, 2, 6 and 7. Bit 1 (reference on) is 1 only for those addresses, only when int_ref is 1, and only on frames that are not the last of their group.
- R4: Bit 0 (converter on) is 1 on every frame of a group except the last. The last frame has bits 1:0 equal to 00.
- R5: Channels are visited in ascending address order and disabled ones are skipped. Each channel sends settle + max(ovs,1) frames, where settle and ovs are its 4-bit fields at bit offset 4·address in settle_frames and oversample.
- R6: The sample is bits 14:3 of the 16-bit word received in bytes 2 and 3 of a frame. Bit 15 and bits 2:0 are ignored whatever their value.
- R7: The first settle frames of a group are discarded. The result is ceil(sum/M) over the M kept samples, and is exact up to settle = 15 and M = 15.
- R8: Results are packed: result[12k+11:12k] holds the k-th enabled channel in ascending order.
- R9: An oversampling field of 0 behaves as 1.
- R10: done is high for exactly one cycle. It rises one cycle after the last result is written, while cs_n is already high.
- R11: With an all-zero enable mask no SCLK edge occurs, and done still pulses.
- R12: The configuration inputs are captured at start. A start pulse or a configuration change during a pass has no effect on that pass and does not launch a second one.
- R13: After reset, cs_n is 1, sclk is 0, done is 0 and all results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (pulse) |
| ch_en | input | 8 | Channel enable mask, bit i = address i |
| settle_frames | input | 32 | Discarded frames per channel, 4 bits per address |
| oversample | input | 32 | Averaged frames per channel, 4 bits per address |
| int_ref | input | 1 | 1 = internal reference in use |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| result | output | 96 | Packed 12-bit averages |
| done | output | 1 | Pass complete (one-cycle pulse) |

## Verification
The modelled converter returns words whose bit 15 and low three bits are set. A design that picked the wrong field would therefore report values off by a factor of eight, or with junk added. Sums that do not divide evenly expose an average that truncates instead of rounding up, and a 15+15 burst exposes an accumulator that is too narrow or a settle prefix that is miscounted. A sparse mask, a zero oversampling field and an empty mask catch three faults: unpacked result slots, a group that sends no kept frame (dividing by zero), and a pass that hangs without done. Each command byte is decoded field by field, which catches a last frame that leaves power bits set and a reference bit applied to differential channels. A start and a configuration change mid-pass catch a design that restarts or uses inputs it should have latched.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
    localparam int ADDR_W     = 3;
    localparam int NCH        = 1 << ADDR_W;
    localparam int SAMP_W     = 12;
    localparam int CMD_BITS   = 8;
    localparam int FRAME_BITS = CMD_BITS + 16;
    localparam int DATA_FIRST = CMD_BITS + 1;           // word bit 15 skipped
    localparam int DATA_LAST  = DATA_FIRST + SAMP_W - 1; // word bit 3

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_ISSUE,
        ST_WAIT,
        ST_STORE,
        ST_FIN
    } seq_state_t;

    function automatic logic single_ended(input logic [ADDR_W-1:0] a);
        return (a == 3'd0) || (a == 3'd2) || (a == 3'd6) || (a == 3'd7);
    endfunction
endpackage

// File: rtl/tscan_cmd.sv
module tscan_cmd
    import tscan_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                int_ref,
    input  logic                last,
    output logic [CMD_BITS-1:0] cmd
);
    logic se;

    always_comb begin
        se  = single_ended(addr);
        // start | address | 12-bit mode | SE | ref on | converter on
        cmd = {1'b1, addr, 1'b0, se, se & int_ref & ~last, ~last};
    end
endmodule

// File: rtl/tscan_frame.sv
module tscan_frame
    import tscan_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                fin,
    output logic [SAMP_W-1:0]   sample
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic                  active;
    logic [DIV_W-1:0]      div_cnt;
    logic [BIT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [SAMP_W-1:0]     rx_sh;
    logic                  sclk_q;
    logic                  fin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_q  <= 1'b0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    tx_sh   <= {cmd, {(FRAME_BITS-CMD_BITS){1'b0}}};
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (div_cnt == DIV_W'(DIV - 1)) begin
                div_cnt <= '0;
                sclk_q  <= ~sclk_q;
                if (!sclk_q) begin
                    // rising edge: keep only the 12 data bits of the word
                    if (bit_cnt >= BIT_W'(DATA_FIRST) && bit_cnt <= BIT_W'(DATA_LAST))
                        rx_sh <= {rx_sh[SAMP_W-2:0], miso};
                end else if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
                    active <= 1'b0;
                    fin_q  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign sclk   = sclk_q;
    assign mosi   = tx_sh[FRAME_BITS-1];
    assign fin    = fin_q;
    assign sample = rx_sh;
endmodule

// File: rtl/tscan_avg.sv
module tscan_avg
    import tscan_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [SAMP_W-1:0] sample,
    input  logic [CNT_W-1:0]  divisor,
    output logic [SAMP_W-1:0] mean
);
    localparam int ACC_W = SAMP_W + CNT_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] quot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (add) acc <= acc + ACC_W'(sample);
    end

    // divisor is never 0 here; acc + d - 1 < d * 2^SAMP_W fits ACC_W
    always_comb begin
        quot = (acc + ACC_W'(divisor) - 1'b1) / ACC_W'(divisor);
        mean = quot[SAMP_W-1:0];
    end
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
    import tscan_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int SCLK_DIV = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NCH-1:0]          ch_en,
    input  logic [NCH*CNT_W-1:0]    settle_frames,
    input  logic [NCH*CNT_W-1:0]    oversample,
    input  logic                    int_ref,
    output logic                    sclk,
    output logic                    cs_n,
    output logic                    mosi,
    input  logic                    miso,
    output logic [NCH*SAMP_W-1:0]   result,
    output logic                    done
);
    seq_state_t state, state_nx;

    logic [NCH-1:0]                en_q;
    logic [NCH*CNT_W-1:0]          settle_q, ovs_q;
    logic                          iref_q;
    logic [ADDR_W-1:0]             idx, grp;
    logic [CNT_W:0]                fidx;
    logic [CNT_W-1:0]              settle_cur, m_cur, ovs_sel;
    logic [CNT_W:0]                total;
    logic                          last, keep;
    logic [NCH-1:0][SAMP_W-1:0]    res_q;

    logic                          go, fin, clr, add;
    logic [CMD_BITS-1:0]           cmd;
    logic [SAMP_W-1:0]             sample, mean;

    assign total   = {1'b0, settle_cur} + {1'b0, m_cur};
    assign last    = (fidx == total - 1'b1);
    assign keep    = (fidx >= {1'b0, settle_cur});
    assign ovs_sel = ovs_q[idx*CNT_W +: CNT_W];

    tscan_cmd u_cmd (
        .addr    (idx),
        .int_ref (iref_q),
        .last    (last),
        .cmd     (cmd)
    );

    tscan_frame #(.DIV(SCLK_DIV)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .cmd    (cmd),
        .miso   (miso),
        .sclk   (sclk),
        .mosi   (mosi),
        .fin    (fin),
        .sample (sample)
    );

    tscan_avg #(.CNT_W(CNT_W)) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .add     (add),
        .sample  (sample),
        .divisor (m_cur),
        .mean    (mean)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SEEK;
            ST_SEEK:  if (en_q[idx])                     state_nx = ST_ISSUE;
                      else if (idx == ADDR_W'(NCH - 1))  state_nx = ST_FIN;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (fin) state_nx = last ? ST_STORE : ST_ISSUE;
            ST_STORE: state_nx = (idx == ADDR_W'(NCH - 1)) ? ST_FIN : ST_SEEK;
            ST_FIN:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs_n = (state == ST_IDLE) || (state == ST_FIN);
        done = (state == ST_FIN);
        go   = (state == ST_ISSUE);
        clr  = (state == ST_SEEK);
        add  = (state == ST_WAIT) && fin && keep;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            settle_q   <= '0;
            ovs_q      <= '0;
            iref_q     <= 1'b0;
            idx        <= '0;
            grp        <= '0;
            fidx       <= '0;
            settle_cur <= '0;
            m_cur      <= CNT_W'(1);
            res_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    en_q     <= ch_en;
                    settle_q <= settle_frames;
                    ovs_q    <= oversample;
                    iref_q   <= int_ref;
                    idx      <= '0;
                    grp      <= '0;
                end
                ST_SEEK: begin
                    if (en_q[idx]) begin
                        settle_cur <= settle_q[idx*CNT_W +: CNT_W];
                        m_cur      <= (ovs_sel == '0) ? CNT_W'(1) : ovs_sel;
                        fidx       <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_WAIT: if (fin) fidx <= fidx + 1'b1;
                ST_STORE: begin
                    res_q[grp] <= mean;
                    grp        <= grp + 1'b1;
                    idx        <= idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign result = res_q;
endmodule

// File: rtl/tscan_sva.sv
module tscan_sva (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic done
);
    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && start) |=> (!cs_n || done));
endmodule

bind touch_scan_seq tscan_sva u_tscan_sva (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi),
    .done  (done)
);

// File: tb/tb_touch_scan_seq.sv
module tb_touch_scan_seq;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ch_en = '0;
    logic [31:0] settle_frames = '0;
    logic [31:0] oversample = '0;
    logic        int_ref = 1'b0;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic [95:0] result;
    logic        done;

    touch_scan_seq #(.CNT_W(CW), .SCLK_DIV(2)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en),
        .settle_frames(settle_frames), .oversample(oversample),
        .int_ref(int_ref), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .result(result), .done(done)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_chk = 0;
    int n_bad = 0;

    // converter model
    logic [7:0] cmd_log [0:511];
    logic [7:0] cmd_sh = '0;
    int rcnt = 0;
    int fcnt = 0;

    function automatic logic [11:0] sval(input int f, input logic [2:0] ch);
        return 12'((int'(ch) * 517 + f * 389 + 123) % 4096);
    endfunction

    always @(posedge sclk) begin
        cmd_sh = {cmd_sh[6:0], mosi};
        if (rcnt % 24 == 7) cmd_log[(rcnt / 24) % 512] = cmd_sh;
        rcnt = rcnt + 1;
    end

    always @(negedge sclk) begin
        int k, f;
        logic [23:0] w;
        fcnt = fcnt + 1;
        k = fcnt % 24;
        f = (fcnt / 24) % 512;
        if (k >= 8) begin
            // junk in bit 15 and bits 2:0
            w = {8'h00, 1'b1, sval(f, cmd_log[f][6:4]), 3'b101};
            miso = w[23 - k];
        end else begin
            miso = 1'b0;
        end
    end

    // expectations
    logic [7:0]  exp_log [0:511];
    logic [11:0] exp_res [0:7];
    int exp_frames, exp_groups;
    logic [3:0] st [0:7];
    logic [3:0] ov [0:7];

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [7:0] mask, input logic iref);
        ch_en = mask;
        int_ref = iref;
        for (int c = 0; c < 8; c++) begin
            settle_frames[c*4 +: 4] = st[c];
            oversample[c*4 +: 4]    = ov[c];
        end
    endtask

    task automatic build_expect(input logic [7:0] mask, input logic iref);
        int f, g, m, n, sum;
        logic se, lst;
        f = 0; g = 0;
        for (int c = 0; c < 8; c++) begin
            if (mask[c]) begin
                m = (ov[c] == 0) ? 1 : int'(ov[c]);
                n = int'(st[c]);
                sum = 0;
                se = (c == 0) || (c == 2) || (c == 6) || (c == 7);
                for (int j = 0; j < n + m; j++) begin
                    lst = (j == n + m - 1);
                    exp_log[f] = {1'b1, 3'(c), 1'b0, se, se & iref & ~lst, ~lst};
                    if (j >= n) sum += int'(sval(f, 3'(c)));
                    f++;
                end
                exp_res[g] = 12'((sum + m - 1) / m);
                g++;
            end
        end
        exp_frames = f;
        exp_groups = g;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done_and_check();
        while (!done) @(negedge clk);
        check("R10", cs_n, 1, "cs_n with done");
        @(negedge clk);
        check("R10", done, 0, "done width");
        check("R1", cs_n, 1, "cs_n after pass");
    endtask

    task automatic compare_pass(input string tag);
        check("R1", rcnt, 24 * exp_frames, {tag, " sclk rising edges"});
        for (int f = 0; f < exp_frames; f++) begin
            check("R2", {cmd_log[f][7], cmd_log[f][3]}, {exp_log[f][7], exp_log[f][3]}, {tag, " start/mode bits"});
            check("R5", cmd_log[f][6:4], exp_log[f][6:4], {tag, " address order"});
            check("R3", cmd_log[f][2:1], exp_log[f][2:1], {tag, " SE/ref bits"});
            check("R4", cmd_log[f][0], exp_log[f][0], {tag, " converter-on bit"});
        end
        for (int g = 0; g < exp_groups; g++)
            check("R7", result[g*12 +: 12], exp_res[g], {tag, " averaged result (R6 R8)"});
    endtask

    task automatic run_scan(input logic [7:0] mask, input logic iref, input string tag);
        rcnt = 0; fcnt = 0;
        apply_cfg(mask, iref);
        build_expect(mask, iref);
        pulse_start();
        wait_done_and_check();
        compare_pass(tag);
    endtask

    task automatic t_reset();
        check("R13", cs_n, 1, "reset cs_n");
        check("R13", sclk, 0, "reset sclk");
        check("R13", done, 0, "reset done");
        check("R13", (result == '0) ? 1 : 0, 1, "reset results zero");
    endtask

    task automatic t_all_default();
        for (int c = 0; c < 8; c++) begin st[c] = 4'd1; ov[c] = 4'd1; end
        run_scan(8'hFF, 1'b1, "all-channels");
    endtask

    task automatic t_sparse();
        for (int c = 0; c < 8; c++) begin st[c] = 4'(c % 3); ov[c] = 4'(2 + c % 4); end
        run_scan(8'b1010_0110, 1'b0, "sparse-R8");
    endtask

    task automatic t_zero_ovs();
        for (int c = 0; c < 8; c++) begin st[c] = 4'd0; ov[c] = 4'd0; end
        run_scan(8'b0100_0001, 1'b1, "ovs0-R9");
    endtask

    task automatic t_max_burst();
        for (int c = 0; c < 8; c++) begin st[c] = 4'd15; ov[c] = 4'd15; end
        run_scan(8'b1000_0000, 1'b1, "max-burst-R7");
    endtask

    task automatic t_empty();
        int lows;
        rcnt = 0; fcnt = 0; lows = 0;
        apply_cfg(8'h00, 1'b1);
        pulse_start();
        while (!done) begin
            @(negedge clk);
            if (!cs_n) lows++;
        end
        check("R11", rcnt, 0, "sclk edges with empty mask");
        check("R11", done, 1, "done with empty mask");
        @(negedge clk);
        check("R10", done, 0, "done width empty");
    endtask

    task automatic t_busy_start();
        logic [7:0] m0;
        for (int c = 0; c < 8; c++) begin st[c] = 4'd1; ov[c] = 4'd2; end
        m0 = 8'b0000_1001;
        rcnt = 0; fcnt = 0;
        apply_cfg(m0, 1'b0);
        build_expect(m0, 1'b0);
        pulse_start();
        repeat (40) @(negedge clk);
        for (int c = 0; c < 8; c++) begin st[c] = 4'd7; ov[c] = 4'd9; end
        apply_cfg(8'hF0, 1'b1);
        pulse_start();
        wait_done_and_check();
        compare_pass("busy-R12");
        repeat (60) @(negedge clk);
        check("R12", cs_n, 1, "no second pass");
        check("R12", rcnt, 24 * exp_frames, "no extra frames");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_all_default();
        t_sparse();
        t_zero_ovs();
        t_max_burst();
        t_empty();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule